// File: doc/BRIEF.md
# Replicated Four-Read Two-Write Register File

This block is the operand store of a small processor core. It must let one instruction of the shape `dest = x op y op z` fetch every source operand in one cycle, and let two results retire in the same cycle. It gets four read ports from storage that has only two ports per copy. The array is built as identical copies, and every write is sent to all of them at once, so the copies never disagree. Each copy then has its two read addresses free: copy 0 serves read ports 0 and 1, and copy 1 serves read ports 2 and 3.

Writes come in on two independent ports, A and B. When both are enabled for the same register in the same cycle, the block raises a clash flag for that cycle and resolves the collision in favour of port A. Reads are registered. A read returns the contents as they stood before any write on the same clock edge. Software writes a register before it first reads it, so the array itself is never cleared. Only the read data registers are reset.

Top module: `rf_quad_read`

## Requirements
- R1: Each of the four read ports returns, one clock edge after its address is presented, the contents of the addressed register, and the four ports work independently with different addresses in the same cycle.
- R2: A write through port A (`wa_en` high) stores `wa_data` at `wa_addr`, and the value is then returned on every one of the four read ports.
- R3: A write through port B (`wb_en` high, no clash) stores `wb_data` at `wb_addr`, and the value is then returned on every one of the four read ports.
- R4: Two enabled writes to different registers in the same cycle are both stored.
- R5: When both write ports are enabled for the same register in one cycle, the port A data is stored, and all four read ports return it afterwards, from both copies alike.
- R6: `wr_clash` is high, combinationally in the same cycle, exactly when both write enables are high and `wa_addr` equals `wb_addr`; it is low when only one port is enabled or the addresses differ.
- R7: A read of a register that is written on the same clock edge returns the old contents (read-first); the new value appears on the following read.
- R8: All read data outputs are zero while `rst_n` is low and remain zero until the first clock edge after its release.
- R9: Register 0 and the highest register are ordinary storage: they can be written and read back like any other.
- R10: With a write enable low, the address and data on that port change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read data registers |
| rd_addr | input | 4 x 5 | Register address for each read port, element i feeds read port i |
| rd_data | output | 4 x 32 | Registered read data, element i belongs to read port i |
| wa_en | input | 1 | Write enable of port A |
| wa_addr | input | 5 | Register written by port A |
| wa_data | input | 32 | Data written by port A |
| wb_en | input | 1 | Write enable of port B |
| wb_addr | input | 5 | Register written by port B |
| wb_data | input | 32 | Data written by port B |
| wr_clash | output | 1 | High when both write ports target one register in the current cycle |

## Verification
Two cases can fall in the same cycle. A write and a read of the same register can meet on one edge, and both write ports can target one register. The bench provokes the first by writing a register while all four read ports point at it. It expects the old value on that edge and the new value on the next one. It provokes the second by enabling A and B on one address with different data. It judges the flag while the request is still applied and then reads the register back through all four ports, where only the A value may appear. The same address is also offered with only one port enabled, and there the flag must stay low.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
    localparam int RF_DEF_REGS       = 32;
    localparam int RF_DEF_WIDTH      = 32;
    localparam int RF_DEF_COPIES     = 2;
    localparam int RF_PORTS_PER_COPY = 2;

    // Classification of the write requests present in one cycle
    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SINGLE,
        WR_DUAL,
        WR_CLASH
    } wr_mode_e;
endpackage

// File: rtl/rf_wr_steer.sv
`timescale 1ns/1ps
module rf_wr_steer import rf_pkg::*; #(
    parameter int AW = 5
) (
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    output logic          a_go,
    output logic          b_go,
    output logic          clash
);
    wr_mode_e mode;

    always_comb begin
        if (a_en && b_en) begin
            mode = (a_addr == b_addr) ? WR_CLASH : WR_DUAL;
        end else if (a_en || b_en) begin
            mode = WR_SINGLE;
        end else begin
            mode = WR_IDLE;
        end
    end

    always_comb begin
        a_go  = 1'b0;
        b_go  = 1'b0;
        clash = 1'b0;
        unique case (mode)
            WR_IDLE: begin
            end
            WR_SINGLE: begin
                a_go = a_en;
                b_go = b_en;
            end
            WR_DUAL: begin
                a_go = 1'b1;
                b_go = 1'b1;
            end
            WR_CLASH: begin
                // port A wins; port B is dropped for this cycle
                a_go  = 1'b1;
                clash = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rf_mirror_bank.sv
`timescale 1ns/1ps
module rf_mirror_bank #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_go,
    input  logic [AW-1:0]     wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_go,
    input  logic [AW-1:0]     wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [AW-1:0]     rd_addr0,
    input  logic [AW-1:0]     rd_addr1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage is never cleared: software writes before it reads
    always_ff @(posedge clk) begin
        if (wb_go) begin
            mem[wb_addr] <= wb_data;
        end
        if (wa_go) begin
            mem[wa_addr] <= wa_data;
        end
    end

    // Registered reads sample the array before this edge's writes land
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data0 <= '0;
            rd_data1 <= '0;
        end else begin
            rd_data0 <= mem[rd_addr0];
            rd_data1 <= mem[rd_addr1];
        end
    end
endmodule

// File: rtl/rf_quad_read.sv
`timescale 1ns/1ps
module rf_quad_read import rf_pkg::*; #(
    parameter  int NUM_REGS   = RF_DEF_REGS,
    parameter  int DATA_W     = RF_DEF_WIDTH,
    parameter  int NUM_COPIES = RF_DEF_COPIES,
    localparam int AW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int RD_PORTS   = NUM_COPIES * RF_PORTS_PER_COPY
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [RD_PORTS-1:0][AW-1:0]      rd_addr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data,
    input  logic                             wa_en,
    input  logic [AW-1:0]                    wa_addr,
    input  logic [DATA_W-1:0]                wa_data,
    input  logic                             wb_en,
    input  logic [AW-1:0]                    wb_addr,
    input  logic [DATA_W-1:0]                wb_data,
    output logic                             wr_clash
);
    logic a_go;
    logic b_go;

    rf_wr_steer #(.AW(AW)) u_steer (
        .a_en   (wa_en),
        .a_addr (wa_addr),
        .b_en   (wb_en),
        .b_addr (wb_addr),
        .a_go   (a_go),
        .b_go   (b_go),
        .clash  (wr_clash)
    );

    // Every copy receives the same write traffic; each serves two read ports
    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        rf_mirror_bank #(
            .DEPTH  (NUM_REGS),
            .DATA_W (DATA_W),
            .AW     (AW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wa_go    (a_go),
            .wa_addr  (wa_addr),
            .wa_data  (wa_data),
            .wb_go    (b_go),
            .wb_addr  (wb_addr),
            .wb_data  (wb_data),
            .rd_addr0 (rd_addr[2*c]),
            .rd_addr1 (rd_addr[2*c+1]),
            .rd_data0 (rd_data[2*c]),
            .rd_data1 (rd_data[2*c+1])
        );
    end
endmodule

// File: rtl/rf_quad_read_chk.sv
`timescale 1ns/1ps
module rf_quad_read_chk import rf_pkg::*; #(
    parameter  int NUM_REGS   = RF_DEF_REGS,
    parameter  int DATA_W     = RF_DEF_WIDTH,
    parameter  int NUM_COPIES = RF_DEF_COPIES,
    localparam int AW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int RD_PORTS   = NUM_COPIES * RF_PORTS_PER_COPY
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [RD_PORTS-1:0][AW-1:0]      rd_addr,
    input logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data,
    input logic                             wa_en,
    input logic [AW-1:0]                    wa_addr,
    input logic [DATA_W-1:0]                wa_data,
    input logic                             wb_en,
    input logic [AW-1:0]                    wb_addr,
    input logic [DATA_W-1:0]                wb_data,
    input logic                             wr_clash
);
    // R6: no clash without both ports enabled
    a_r6_clash_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clash |-> (wa_en && wb_en));

    // R6: distinct addresses never clash
    a_r6_distinct_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && (wa_addr != wb_addr)) |-> !wr_clash);

    // R8: first edge after release still shows reset data
    a_r8_release_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == '0));

    // R2: port A data read back on port 0
    a_r2_write_a_seen: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en ##1 (rd_addr[0] == $past(wa_addr)) |=> (rd_data[0] == $past(wa_data, 2)));

    // R3: port B data read back on port 1 when not overridden
    a_r3_write_b_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(wa_en && (wa_addr == wb_addr))) ##1 (rd_addr[1] == $past(wb_addr))
        |=> (rd_data[1] == $past(wb_data, 2)));

    // R5: all copies hold identical contents
    for (genvar c = 1; c < NUM_COPIES; c++) begin : g_agree
        a_r5_copies_agree_even: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_addr[0] == rd_addr[2*c]) |-> (rd_data[0] == rd_data[2*c]));
        a_r5_copies_agree_odd: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_addr[1] == rd_addr[2*c+1]) |-> (rd_data[1] == rd_data[2*c+1]));
    end
endmodule

bind rf_quad_read rf_quad_read_chk #(
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W),
    .NUM_COPIES (NUM_COPIES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wa_en    (wa_en),
    .wa_addr  (wa_addr),
    .wa_data  (wa_data),
    .wb_en    (wb_en),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .wr_clash (wr_clash)
);

// File: tb/test_rf_quad_read.sv
`timescale 1ns/1ps
module test_rf_quad_read;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0][4:0]  rd_addr = '0;
    logic [3:0][31:0] rd_data;
    logic             wa_en = 1'b0;
    logic [4:0]       wa_addr = '0;
    logic [31:0]      wa_data = '0;
    logic             wb_en = 1'b0;
    logic [4:0]       wb_addr = '0;
    logic [31:0]      wb_data = '0;
    logic             wr_clash;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] model [32];

    always #5 clk = ~clk;

    rf_quad_read i_rf_quad_read (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .wr_clash(wr_clash)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of writes, check the clash flag while applied, update model
    task automatic write2(input string tag,
                          input logic ea, input logic [4:0] aa, input logic [31:0] da,
                          input logic eb, input logic [4:0] ab, input logic [31:0] db,
                          input logic exp_clash);
        @(negedge clk);
        wa_en = ea; wa_addr = aa; wa_data = da;
        wb_en = eb; wb_addr = ab; wb_data = db;
        #1;
        chk({tag, " R6 clash flag"}, {31'd0, wr_clash}, {31'd0, exp_clash});
        @(negedge clk);
        wa_en = 1'b0; wb_en = 1'b0;
        if (eb) model[ab] = db;
        if (ea) model[aa] = da;
    endtask

    task automatic read4(input string tag, input logic [4:0] a0, input logic [4:0] a1,
                         input logic [4:0] a2, input logic [4:0] a3);
        @(negedge clk);
        rd_addr[0] = a0; rd_addr[1] = a1; rd_addr[2] = a2; rd_addr[3] = a3;
        @(negedge clk);
        chk({tag, " port0"}, rd_data[0], model[a0]);
        chk({tag, " port1"}, rd_data[1], model[a1]);
        chk({tag, " port2"}, rd_data[2], model[a2]);
        chk({tag, " port3"}, rd_data[3], model[a3]);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R8 in reset", rd_data[i], 32'd0);
        rd_addr = {5'd3, 5'd2, 5'd1, 5'd0};
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < 4; i++) chk("R8 after release", rd_data[i], 32'd0);
    endtask

    task automatic t_fill();
        for (int r = 0; r < 16; r++) begin
            write2("R4 fill", 1'b1, 5'(r), 32'h1000_0000 + r * 32'h111,
                   1'b1, 5'(r + 16), 32'h2000_0000 + r * 32'h111, 1'b0);
        end
        for (int r = 0; r < 32; r += 4) begin
            read4("R4 R1 readback", 5'(r), 5'(r + 1), 5'(r + 2), 5'(r + 3));
        end
    endtask

    task automatic t_distinct_ports();
        read4("R1 mixed addresses", 5'd30, 5'd4, 5'd17, 5'd9);
    endtask

    task automatic t_write_a();
        write2("R2 write A", 1'b1, 5'd12, 32'hCAFE_0012, 1'b0, 5'd12, 32'h0, 1'b0);
        read4("R2 all ports", 5'd12, 5'd12, 5'd12, 5'd12);
    endtask

    task automatic t_write_b();
        write2("R3 write B", 1'b0, 5'd20, 32'h0, 1'b1, 5'd20, 32'hBEEF_0020, 1'b0);
        read4("R3 all ports", 5'd20, 5'd20, 5'd20, 5'd20);
    endtask

    task automatic t_edge_regs();
        write2("R9 edges", 1'b1, 5'd0, 32'h0000_F00D, 1'b1, 5'd31, 32'hFFFF_0031, 1'b0);
        read4("R9 reg0 and reg31", 5'd0, 5'd31, 5'd31, 5'd0);
    endtask

    task automatic t_enable_low();
        write2("R10 no enable", 1'b0, 5'd3, 32'hDEAD_DEAD, 1'b0, 5'd5, 32'hDEAD_BEEF, 1'b0);
        read4("R10 untouched", 5'd3, 5'd5, 5'd3, 5'd5);
    endtask

    task automatic t_clash();
        write2("R5 same address", 1'b1, 5'd9, 32'hAAAA_0009, 1'b1, 5'd9, 32'hBBBB_0009, 1'b1);
        chk("R5 model holds A data", model[9], 32'hAAAA_0009);
        read4("R5 A wins on all ports", 5'd9, 5'd9, 5'd9, 5'd9);
        write2("R6 one enable same addr", 1'b0, 5'd14, 32'h0, 1'b1, 5'd14, 32'h5151_0014, 1'b0);
        read4("R6 R3 B stored", 5'd14, 5'd14, 5'd14, 5'd14);
    endtask

    task automatic t_read_first();
        logic [31:0] old_v;
        old_v = model[7];
        @(negedge clk);
        rd_addr = {5'd7, 5'd7, 5'd7, 5'd7};
        wa_en = 1'b1; wa_addr = 5'd7; wa_data = 32'h7777_0007;
        @(negedge clk);
        wa_en = 1'b0;
        model[7] = 32'h7777_0007;
        for (int i = 0; i < 4; i++) chk("R7 same-edge read old", rd_data[i], old_v);
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R7 next read new", rd_data[i], 32'h7777_0007);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        t_reset();
        t_fill();
        t_distinct_ports();
        t_write_a();
        t_write_b();
        t_edge_regs();
        t_enable_low();
        t_clash();
        t_read_first();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule